// File: doc/BRIEF.md
# UART Controller with FIFOs and Set/Clear Flag Register

The block is an asynchronous serial port for a processor bus. Software reaches it through a small word-addressed register port. A write to the transmit data register queues a byte in a transmit FIFO. A serializer pulls queued bytes and sends them on `txd`. On the receive side, a deserializer collects frames from `rxd` into a receive FIFO, and reads of the receive data register pop that FIFO one entry at a time. A status register reports both fill levels. Each FIFO has its own control register. It can empty the FIFO in one write, or cut its capacity to a single entry.

The frame format is set in the control register: the data width (7 or 8 bits), whether a parity bit is sent and checked, odd or even parity, and one or two stop bits. A loopback bit routes the transmitter into the receiver inside the block. Parity, framing and overrun errors raise sticky flags, and each error class has its own check enable. The receiver-enable bit and the three error flags cannot be changed by writing the control register. They change only through a write-only set/clear register, which has a separate set bit and clear bit for each of them.

The bit clock comes from outside as `bit_tick`, a one-cycle pulse per bit period. Each bit on the line lasts exactly one tick period. The receiver samples the line once per tick.

Top module: `uart_ctl`

Register word addresses: 0 control, 1 transmit data (write), 2 receive data (read), 3 status, 4 transmit FIFO control, 5 receive FIFO control, 6 set/clear (write-only, reads 0).

## Requirements
- R1: After reset, the control register reads 0x0001 (8-bit asynchronous mode, receiver off, no checks, no flags). Status reads 0. Both FIFO control registers read 0x0001 (enabled). `txd` is high.
- R2: A control write stores bits [2:0] (mode), 3 (two stop bits), 5 (parity check), 6 (framing check), 7 (overrun check), 12 (odd parity) and 14 (loopback). It leaves bit 4 (receiver enable) and bits 8, 9 and 10 (parity, framing and overrun flags) unchanged.
- R3: In the set/clear register, bit 5 sets and bit 4 clears receiver enable. Bits 11, 12 and 13 set the parity, framing and overrun flags, and bits 8, 9 and 10 clear them. A write that asserts both the set bit and the clear bit of one item leaves that item unchanged.
- R4: A transmit frame is: a start bit (0), the data bits LSB first, a parity bit in mode 3 (7 data bits) or mode 7 (8 data bits), then one stop bit, or two when control bit 3 is set. Every other mode code sends 8 data bits with no parity. Each bit lasts one tick period, and the start bit appears on the tick after which a byte is waiting.
- R5: The parity bit makes the count of ones in data plus parity even when control bit 12 is 0, and odd when it is 1.
- R6: Status bits [5:0] give the receive FIFO level and bits [13:8] give the transmit FIFO level. A transmit level of 16 means full, and further transmit writes are dropped.
- R7: A receive data read returns the oldest entry in bits [7:0] and pops it. A read when the FIFO is empty returns the last value read and changes no level.
- R8: When control bit 14 is set, the receiver takes the transmitter's line and `txd` stays high.
- R9: When receiver enable is 0, activity on the line stores nothing.
- R10: With the parity check on (bit 5), a received parity mismatch sets the parity flag (bit 8). The character is still stored. The flag stays set through later good characters until it is cleared. With the check off, no flag is raised.
- R11: With the framing check on (bit 6), a received stop bit of 0 sets the framing flag (bit 9).
- R12: A character that completes while the receive FIFO is full is dropped. The overrun flag (bit 10) is set only if the overrun check (bit 7) is on.
- R13: In a FIFO control register, writing bit 1 empties that FIFO, and bit 1 reads back as 0. Bit 0 = 0 limits the FIFO to one entry. Bit 2 and bits [13:8] are stored and read back.
- R14: In mode 3, received data reads with bit 7 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 2) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, valid in the same cycle |
| bit_tick | input | 1 | One pulse per bit period from an external rate generator |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
A wrong serializer shift count or bit-order fault shows on `txd` within a single frame, at the first bit position that goes wrong. A receive decode fault shows only when the byte is read back, so loopback runs compare every received byte with the byte that was written. A flag update that is wrong shows in the control word on the read right after the offending set/clear write or frame. A FIFO pointer or level fault shows in the status word, or as bytes read back out of order. Near-full and full states are driven on purpose, because a dropped byte stays hidden until a whole burst is read back.

// File: rtl/uart_pkg.sv
`timescale 1ns/1ps
package uart_pkg;

    localparam int FRAME_MAX = 12;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_TXD    = 3'd1,
        A_RXD    = 3'd2,
        A_STAT   = 3'd3,
        A_TXFC   = 3'd4,
        A_RXFC   = 3'd5,
        A_SETCLR = 3'd6
    } reg_addr_e;

    typedef enum logic [2:0] {
        M_SYNC8   = 3'd0,
        M_ASYNC8  = 3'd1,
        M_IRDA    = 3'd2,
        M_ASYNC7P = 3'd3,
        M_ASYNC9  = 3'd4,
        M_WAKE8   = 3'd5,
        M_RSVD    = 3'd6,
        M_ASYNC8P = 3'd7
    } frame_mode_e;

    typedef struct packed {
        frame_mode_e mode;
        logic        two_stop;
        logic        odd;
    } line_cfg_t;

    typedef struct packed {
        logic       en;
        logic       transp;
        logic [5:0] trig;
    } fifo_cfg_t;

    // control word bit positions (software decodes these)
    localparam int B_STP = 3,  B_REN = 4,  B_PEN = 5,  B_FEN = 6, B_OEN = 7;
    localparam int B_PE  = 8,  B_FE  = 9,  B_OE  = 10, B_ODD = 12, B_LB = 14;
    // set/clear word bit positions
    localparam int S_CLR_REN = 4, S_SET_REN = 5;
    localparam int S_CLR_PE = 8,  S_CLR_FE = 9,  S_CLR_OE = 10;
    localparam int S_SET_PE = 11, S_SET_FE = 12, S_SET_OE = 13;
    // fifo control bit positions
    localparam int F_EN = 0, F_FLUSH = 1, F_TM = 2;

    function automatic int data_bits(frame_mode_e m);
        return (m == M_ASYNC7P) ? 7 : 8;
    endfunction

    function automatic logic has_parity(frame_mode_e m);
        return (m == M_ASYNC7P) || (m == M_ASYNC8P);
    endfunction

    function automatic logic [3:0] frame_len(line_cfg_t c);
        return 4'(1 + data_bits(c.mode) + int'(has_parity(c.mode)) + (c.two_stop ? 2 : 1));
    endfunction

    function automatic logic sc_update(logic cur, logic set, logic clr);
        if (set && !clr) return 1'b1;
        if (clr && !set) return 1'b0;
        return cur;
    endfunction

    function automatic logic [15:0] fc_word(fifo_cfg_t c);
        return {2'b00, c.trig, 5'b00000, c.transp, 1'b0, c.en};
    endfunction

endpackage

// File: rtl/uart_fifo.sv
`timescale 1ns/1ps
module uart_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 16,
    localparam int LW    = $clog2(DEPTH + 1),
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = single ? !empty : (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rp    <= '0;
            wp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

endmodule

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
module uart_tx import uart_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  line_cfg_t cfg,
    input  logic      avail,
    input  logic [7:0] data,
    output logic      take,
    output logic      line
);
    logic [FRAME_MAX-1:0] sh, frame;
    logic [3:0]           left;
    logic [7:0]           dm;
    int                   nb;

    always_comb begin
        nb       = data_bits(cfg.mode);
        dm       = (nb == 7) ? {1'b0, data[6:0]} : data;
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++)
            if (i < nb) frame[1 + i] = dm[i];
        if (has_parity(cfg.mode)) frame[1 + nb] = (^dm) ^ cfg.odd;
    end

    assign take = tick && (left == 4'd0) && avail;
    assign line = sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= 4'd0;
        end else if (tick) begin
            if (left != 4'd0) begin
                sh   <= {1'b1, sh[FRAME_MAX-1:1]};
                left <= left - 4'd1;
            end else if (avail) begin
                sh   <= frame;
                left <= frame_len(cfg) - 4'd1;
            end
        end
    end

endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
module uart_rx import uart_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  line_cfg_t  cfg,
    input  logic       line,
    output logic       done,
    output logic [7:0] data,
    output logic       par_bad,
    output logic       stop_bad
);
    logic [FRAME_MAX-1:0] sr, fv;
    logic [3:0]           idx;
    logic                 busy;
    line_cfg_t            cur;
    int                   nd, sp;

    always_comb begin
        fv       = sr;
        fv[idx]  = line;
        nd       = data_bits(cur.mode);
        sp       = nd + int'(has_parity(cur.mode));
        data     = (nd == 7) ? {1'b0, fv[6:0]} : fv[7:0];
        par_bad  = has_parity(cur.mode) && (((^data) ^ fv[nd]) != cur.odd);
        stop_bad = !fv[sp] || (cur.two_stop && !fv[sp + 1]);
    end

    assign done = busy && en && tick && (idx == frame_len(cur) - 4'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= 4'd0;
            sr   <= '0;
            cur  <= '{mode: M_ASYNC8, two_stop: 1'b0, odd: 1'b0};
        end else if (!en) begin
            busy <= 1'b0;
        end else if (tick) begin
            if (!busy) begin
                if (!line) begin
                    busy <= 1'b1;
                    idx  <= 4'd0;
                    cur  <= cfg;
                end
            end else begin
                sr <= fv;
                if (done) busy <= 1'b0;
                else      idx  <= idx + 4'd1;
            end
        end
    end

endmodule

// File: rtl/uart_ctl.sv
`timescale 1ns/1ps
module uart_ctl import uart_pkg::*; #(
    parameter int FIFO_DEPTH = 16
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        bit_tick,
    input  logic        rxd,
    output logic        txd
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    line_cfg_t  cfg;
    fifo_cfg_t  txfc, rxfc;
    logic       ren, pen, fen, oen, lb, pe, fe, oe;
    logic [7:0] last_rx;
    logic [1:0] rx_sync;
    logic [15:0] ctrl_word;
    logic       unused_bits;

    logic wr_ctl, wr_txd, wr_txfc, wr_rxfc, wr_sc, rd_rxd;
    assign wr_ctl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_txd  = bus_wr && (bus_addr == A_TXD);
    assign wr_txfc = bus_wr && (bus_addr == A_TXFC);
    assign wr_rxfc = bus_wr && (bus_addr == A_RXFC);
    assign wr_sc   = bus_wr && (bus_addr == A_SETCLR);
    assign rd_rxd  = bus_rd && (bus_addr == A_RXD);
    assign unused_bits = bus_wdata[15];

    // transmit path
    logic [7:0]    tx_head;
    logic [LW-1:0] tx_level;
    logic          tx_full, tx_empty, tx_take, tx_line;

    uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk, .rst,
        .flush (wr_txfc && bus_wdata[F_FLUSH]),
        .single(!txfc.en),
        .push  (wr_txd), .wdata(bus_wdata[7:0]),
        .pop   (tx_take), .head(tx_head),
        .level (tx_level), .full(tx_full), .empty(tx_empty)
    );

    uart_tx u_ser (
        .clk, .rst, .tick(bit_tick), .cfg,
        .avail(!tx_empty), .data(tx_head), .take(tx_take), .line(tx_line)
    );

    assign txd = lb ? 1'b1 : tx_line;

    // receive path
    logic [7:0]    rx_data, rx_head;
    logic [LW-1:0] rx_level;
    logic          rx_done, rx_par_bad, rx_stop_bad, rx_full, rx_empty;

    always_ff @(posedge clk) begin
        if (rst) rx_sync <= 2'b11;
        else     rx_sync <= {rx_sync[0], rxd};
    end

    uart_rx u_des (
        .clk, .rst, .tick(bit_tick), .en(ren), .cfg,
        .line(lb ? tx_line : rx_sync[1]),
        .done(rx_done), .data(rx_data),
        .par_bad(rx_par_bad), .stop_bad(rx_stop_bad)
    );

    uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk, .rst,
        .flush (wr_rxfc && bus_wdata[F_FLUSH]),
        .single(!rxfc.en),
        .push  (rx_done), .wdata(rx_data),
        .pop   (rd_rxd), .head(rx_head),
        .level (rx_level), .full(rx_full), .empty(rx_empty)
    );

    // register state
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '{mode: M_ASYNC8, two_stop: 1'b0, odd: 1'b0};
            {pen, fen, oen, lb} <= 4'b0000;
            {ren, pe, fe, oe}   <= 4'b0000;
            txfc    <= '{en: 1'b1, transp: 1'b0, trig: 6'd0};
            rxfc    <= '{en: 1'b1, transp: 1'b0, trig: 6'd0};
            last_rx <= 8'h00;
        end else begin
            if (wr_ctl) begin
                cfg.mode     <= frame_mode_e'(bus_wdata[2:0]);
                cfg.two_stop <= bus_wdata[B_STP];
                cfg.odd      <= bus_wdata[B_ODD];
                pen          <= bus_wdata[B_PEN];
                fen          <= bus_wdata[B_FEN];
                oen          <= bus_wdata[B_OEN];
                lb           <= bus_wdata[B_LB];
            end
            if (wr_txfc) txfc <= '{en: bus_wdata[F_EN], transp: bus_wdata[F_TM], trig: bus_wdata[13:8]};
            if (wr_rxfc) rxfc <= '{en: bus_wdata[F_EN], transp: bus_wdata[F_TM], trig: bus_wdata[13:8]};
            ren <= sc_update(ren, wr_sc && bus_wdata[S_SET_REN], wr_sc && bus_wdata[S_CLR_REN]);
            pe  <= sc_update(pe, wr_sc && bus_wdata[S_SET_PE], wr_sc && bus_wdata[S_CLR_PE])
                   | (rx_done && pen && rx_par_bad);
            fe  <= sc_update(fe, wr_sc && bus_wdata[S_SET_FE], wr_sc && bus_wdata[S_CLR_FE])
                   | (rx_done && fen && rx_stop_bad);
            oe  <= sc_update(oe, wr_sc && bus_wdata[S_SET_OE], wr_sc && bus_wdata[S_CLR_OE])
                   | (rx_done && rx_full && oen);
            if (rd_rxd && !rx_empty) last_rx <= rx_head;
        end
    end

    always_comb begin
        ctrl_word        = '0;
        ctrl_word[2:0]   = cfg.mode;
        ctrl_word[B_STP] = cfg.two_stop;
        ctrl_word[B_REN] = ren;
        ctrl_word[B_PEN] = pen;
        ctrl_word[B_FEN] = fen;
        ctrl_word[B_OEN] = oen;
        ctrl_word[B_PE]  = pe;
        ctrl_word[B_FE]  = fe;
        ctrl_word[B_OE]  = oe;
        ctrl_word[B_ODD] = cfg.odd;
        ctrl_word[B_LB]  = lb;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_word;
            A_RXD:   bus_rdata = {8'h00, rx_empty ? last_rx : rx_head};
            A_STAT:  bus_rdata = {2'b00, 6'(tx_level), 2'b00, 6'(rx_level)};
            A_TXFC:  bus_rdata = fc_word(txfc);
            A_RXFC:  bus_rdata = fc_word(rxfc);
            default: bus_rdata = 16'h0000;
        endcase
    end

endmodule

// File: rtl/uart_ctl_chk.sv
`timescale 1ns/1ps
module uart_ctl_chk #(
    parameter  int DEPTH = 16,
    localparam int LW    = $clog2(DEPTH + 1)
)(
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic [15:0]   bus_wdata,
    input logic          bit_tick,
    input logic          txd,
    input logic          lb,
    input logic          ren,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level
);
    // R6
    tx_lvl_cap_chk: assert property (@(posedge clk) disable iff (rst)
        tx_level <= LW'(DEPTH));

    // R12
    rx_lvl_cap_chk: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LW'(DEPTH));

    // R8
    lb_txd_high_chk: assert property (@(posedge clk) disable iff (rst)
        lb |-> txd);

    // R4
    txd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick && !(bus_wr && bus_addr == 3'd0)) |=> $stable(txd));

    // R3
    ren_both_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd6 && bus_wdata[4] && bus_wdata[5]) |=> $stable(ren));

    // R3
    ren_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd6 && bus_wdata[4] && !bus_wdata[5]) |=> !ren);

    // R2
    ren_ctlwr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0) |=> $stable(ren));

endmodule

bind uart_ctl uart_ctl_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bit_tick(bit_tick), .txd(txd), .lb(lb), .ren(ren),
    .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/sim_uart_ctl.sv
`timescale 1ns/1ps
module sim_uart_ctl;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        bit_tick = 1'b0, rxd = 1'b1;
    logic        txd;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    uart_ctl u0 (
        .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .bit_tick, .rxd, .txd
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask

    function automatic logic [15:0] ctl(input int mode, input bit two, input bit pen,
                                        input bit fen, input bit oen, input bit odd, input bit lb);
        return 16'(mode) | (16'(two) << 3) | (16'(pen) << 5) | (16'(fen) << 6)
             | (16'(oen) << 7) | (16'(odd) << 12) | (16'(lb) << 14);
    endfunction

    function automatic int nbits(input int mode);
        return (mode == 3) ? 7 : 8;
    endfunction

    function automatic bit par_on(input int mode);
        return (mode == 3) || (mode == 7);
    endfunction

    function automatic int flen(input int mode, input bit two);
        return 1 + nbits(mode) + int'(par_on(mode)) + (two ? 2 : 1);
    endfunction

    function automatic logic [7:0] dmask(input logic [7:0] d, input int mode);
        return (mode == 3) ? {1'b0, d[6:0]} : d;
    endfunction

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input int mode, input bit odd);
        logic [11:0] f;
        logic [7:0]  dm;
        dm   = dmask(d, mode);
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nbits(mode); i++) f[1 + i] = dm[i];
        if (par_on(mode)) f[1 + nbits(mode)] = (^dm) ^ odd;
        return f;
    endfunction

    task automatic send_rx(input logic [11:0] f, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk); rxd = f[i];
            repeat (3) @(negedge clk);
            tick();
        end
        @(negedge clk); rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic tx_frame(input string req, input int mode, input bit two, input bit odd,
                            input logic [7:0] d);
        logic [11:0] got;
        logic [15:0] r;
        got = '1;
        wr(3'd0, ctl(mode, two, 1'b0, 1'b0, 1'b0, odd, 1'b0));
        wr(3'd1, {8'h00, d});
        rd(3'd3, r);
        check("R6 tx level after one write", r, 16'h0100);
        for (int i = 0; i < flen(mode, two); i++) begin
            tick();
            got[i] = txd;
        end
        check(req, got, exp_frame(d, mode, odd));
        tick();
        check("R4 line idle after frame", txd, 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [7:0]  sent [16];
        logic [7:0]  last;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, r); check("R1 control reset", r, 16'h0001);
        rd(3'd3, r); check("R1 status reset", r, 16'h0000);
        rd(3'd4, r); check("R1 tx fifo ctl reset", r, 16'h0001);
        rd(3'd5, r); check("R1 rx fifo ctl reset", r, 16'h0001);
        check("R1 txd idle", txd, 1'b1);

        // R2 protected bits in control write
        wr(3'd0, 16'hFFFF);
        rd(3'd0, r); check("R2 control write mask", r, 16'h50EF);
        wr(3'd0, 16'h0001);

        // R3 set/clear register
        wr(3'd6, 16'h0020); rd(3'd0, r); check("R3 set receiver enable", r, 16'h0011);
        wr(3'd6, 16'h0030); rd(3'd0, r); check("R3 set+clear enable unchanged", r, 16'h0011);
        wr(3'd6, 16'h0010); rd(3'd0, r); check("R3 clear receiver enable", r, 16'h0001);
        wr(3'd6, 16'h3800); rd(3'd0, r); check("R3 set all flags", r, 16'h0701);
        wr(3'd6, 16'h0900); rd(3'd0, r); check("R3 set+clear parity flag unchanged", r, 16'h0701);
        wr(3'd6, 16'h0600); rd(3'd0, r); check("R3 clear framing and overrun", r, 16'h0101);
        wr(3'd6, 16'h0100); rd(3'd0, r); check("R3 clear parity flag", r, 16'h0001);

        // R4 / R5 transmit frames
        tx_frame("R4 8-bit no parity one stop", 1, 1'b0, 1'b0, 8'hA5);
        tx_frame("R5 8-bit odd parity two stops", 7, 1'b1, 1'b1, 8'h3C);
        tx_frame("R5 7-bit even parity", 3, 1'b0, 1'b0, 8'hD5);
        tx_frame("R4 unlisted mode sends 8 bits", 5, 1'b0, 1'b0, 8'h81);

        // R6 / R13 fifo full, flush, single entry
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 0));
        for (int i = 0; i < 17; i++) wr(3'd1, 16'(i));
        rd(3'd3, r); check("R6 tx full at 16", r, 16'h1000);
        wr(3'd4, 16'h2A07);
        rd(3'd3, r); check("R13 flush empties tx", r, 16'h0000);
        rd(3'd4, r); check("R13 fifo ctl readback, flush reads 0", r, 16'h2A05);
        wr(3'd4, 16'h0000);
        for (int i = 0; i < 3; i++) wr(3'd1, 16'h0055);
        rd(3'd3, r); check("R13 disabled fifo holds one", r, 16'h0100);
        wr(3'd4, 16'h0003);

        // R8 / R14 / R7 randomized loopback runs
        wr(3'd6, 16'h0020);
        for (int it = 0; it < 20; it++) begin
            int  mode, n;
            bit  two, odd, line_ok;
            logic [7:0] b;
            case ($urandom_range(0, 2))
                0:       mode = 1;
                1:       mode = 3;
                default: mode = 7;
            endcase
            two = 1'($urandom_range(0, 1));
            odd = 1'($urandom_range(0, 1));
            n   = $urandom_range(1, 5);
            wr(3'd0, ctl(mode, two, 1'b1, 1'b1, 1'b1, odd, 1'b1));
            for (int k = 0; k < n; k++) begin
                sent[k] = 8'($urandom);
                wr(3'd1, {8'h00, sent[k]});
            end
            line_ok = 1'b1;
            for (int t = 0; t < n * flen(mode, two) + 2; t++) begin
                tick();
                if (txd !== 1'b1) line_ok = 1'b0;
            end
            check("R8 txd high in loopback", line_ok, 1'b1);
            rd(3'd3, r); check("R8 loopback receive level", r, 16'(n));
            for (int k = 0; k < n; k++) begin
                rd(3'd2, r);
                check((mode == 3) ? "R14 7-bit read data" : "R8 loopback data", r,
                      {8'h00, dmask(sent[k], mode)});
                last = dmask(sent[k], mode);
            end
            rd(3'd0, r); check("R8 no error flags in loopback", r[10:8], 3'b000);
        end

        // R7 empty read
        rd(3'd2, r); check("R7 empty read returns last", r, {8'h00, last});
        rd(3'd3, r); check("R7 empty read leaves level", r, 16'h0000);

        // R9 receiver disabled
        wr(3'd0, ctl(7, 0, 1, 1, 1, 0, 0));
        wr(3'd6, 16'h0010);
        send_rx(exp_frame(8'h5A, 7, 1'b0), flen(7, 1'b0));
        rd(3'd3, r); check("R9 disabled receiver stores nothing", r, 16'h0000);

        // R10 parity errors
        wr(3'd6, 16'h0020);
        send_rx(exp_frame(8'h5A, 7, 1'b0), flen(7, 1'b0));
        rd(3'd2, r); check("R10 good frame data", r, 16'h005A);
        rd(3'd0, r); check("R10 good frame no flag", r[10:8], 3'b000);
        send_rx(exp_frame(8'h33, 7, 1'b0) ^ 12'h200, flen(7, 1'b0));
        rd(3'd0, r); check("R10 parity flag set", r[10:8], 3'b001);
        rd(3'd2, r); check("R10 bad parity char stored", r, 16'h0033);
        send_rx(exp_frame(8'h0F, 7, 1'b0), flen(7, 1'b0));
        rd(3'd2, r);
        rd(3'd0, r); check("R10 parity flag sticky", r[10:8], 3'b001);
        wr(3'd6, 16'h0100);
        wr(3'd0, ctl(7, 0, 0, 1, 1, 0, 0));
        send_rx(exp_frame(8'h33, 7, 1'b0) ^ 12'h200, flen(7, 1'b0));
        rd(3'd2, r);
        rd(3'd0, r); check("R10 check off, no flag", r[10:8], 3'b000);

        // R11 framing error
        wr(3'd0, ctl(7, 0, 1, 1, 1, 0, 0));
        send_rx(exp_frame(8'hC3, 7, 1'b0) ^ 12'h400, flen(7, 1'b0));
        rd(3'd2, r);
        rd(3'd0, r); check("R11 framing flag set", r[10:8], 3'b010);
        wr(3'd6, 16'h0200);

        // R12 overrun
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 1));
        for (int k = 0; k < 16; k++) begin
            sent[k] = 8'(k * 13 + 5);
            wr(3'd1, {8'h00, sent[k]});
        end
        repeat (16 * 10 + 2) tick();
        wr(3'd1, 16'h00EE);
        repeat (12) tick();
        rd(3'd3, r); check("R12 rx full level", r, 16'h0010);
        rd(3'd0, r); check("R12 no overrun flag when check off", r[10:8], 3'b000);
        wr(3'd0, ctl(1, 0, 0, 0, 1, 0, 1));
        wr(3'd1, 16'h00DD);
        repeat (12) tick();
        rd(3'd0, r); check("R12 overrun flag set", r[10:8], 3'b100);
        rd(3'd3, r); check("R12 level unchanged on overrun", r, 16'h0010);
        begin
            bit ok;
            ok = 1'b1;
            for (int k = 0; k < 16; k++) begin
                rd(3'd2, r);
                if (r !== {8'h00, sent[k]}) ok = 1'b0;
            end
            check("R12 stored order, extra chars dropped", ok, 1'b1);
        end
        rd(3'd2, r); check("R7 empty read after drain", r, {8'h00, sent[15]});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule